// File: doc/BRIEF.md
# Register Readiness Scoreboard with Consumer Wakeup

This block keeps one readiness bit per physical register and a small set of issue-window slots. Each slot records which of its two source operands are still outstanding. Dispatch writes an instruction into a chosen slot. It supplies two source tags, the readiness rename already knows for each source, and one destination tag. A source that rename reports as not ready is checked again against the scoreboard, and against a completion arriving in the same cycle, so that a value produced while the instruction was in flight does not leave it waiting.

When a completion names a register, the block sets that register's scoreboard bit and clears the matching pending bit in every slot that waits on it. Each slot raises its ready-to-issue line as soon as it holds a valid instruction with no pending source. Tags at or above the physical register count carry no tracking: they never make a source wait and never change the scoreboard. A drop mask removes slots from the window, whether they issued or were squashed, and takes them out of every waiter set. A destination that is dispatched while consumers still wait on that register is a protocol error, and it sets a sticky error flag.

Top module: `regwake_tracker`

## Requirements
- R1: After synchronous reset every scoreboard bit reads not-ready, no slot is ready, and the error flag is low.
- R2: A dispatch with a tracked destination tag clears that register's scoreboard bit. The cleared bit is visible on `reg_ready` after the dispatch edge.
- R3: A dispatched source is not pending if rename marks it ready or if its scoreboard bit is set. A slot with no pending source shows `slot_ready` high after the dispatch edge.
- R4: A source that is not marked ready, whose tag is tracked and whose scoreboard bit is clear, keeps its slot's `slot_ready` low until a completion names that tag.
- R5: A completion with a tracked tag sets that scoreboard bit. It also clears the pending bit of every slot source that waits on that tag, and each such slot with nothing else pending shows ready after that edge.
- R6: A dispatch whose source tag equals the tag of a completion in the same cycle treats that source as ready.
- R7: A tag whose value is 16 or more (the physical register count) is never pending as a source. As a destination or as a completion it leaves `reg_ready` unchanged.
- R8: A dispatch whose tracked destination still has a waiting consumer after this cycle's completion and drops sets `producer_err`, and the flag stays set until reset.
- R9: A slot whose bit is set in `drop_mask` (bit k is slot k) and that is not being dispatched in the same cycle becomes empty, shows not ready, and no longer counts as a waiter for R8.
- R10: When a dispatch destination and a completion name the same tracked tag in one cycle, the scoreboard bit ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch strobe |
| disp_slot | input | 3 | Slot that receives the dispatched instruction |
| disp_src0_tag | input | 5 | First source register tag |
| disp_src1_tag | input | 5 | Second source register tag |
| disp_src_rdy | input | 2 | Readiness known at rename; bit 0 is the first source, bit 1 the second |
| disp_dst_tag | input | 5 | Destination register tag |
| cmpl_valid | input | 1 | Completion strobe |
| cmpl_tag | input | 5 | Tag of the register just produced |
| drop_mask | input | 8 | Slots that leave the window, one bit per slot |
| slot_ready | output | 8 | Per-slot ready-to-issue |
| reg_ready | output | 16 | Scoreboard bits, one per physical register |
| producer_err | output | 1 | Sticky flag for a new producer that still has waiters |

## Verification
Every result comes from a register, so each output changes at the first rising edge after the inputs that caused it. No output changes in the same cycle as its stimulus. The bench drives inputs on the falling edge and samples outputs on the next falling edge, which is half a period after the edge that updates them. A behavioural model advances on the same rising edge from the same inputs and is compared with all three outputs at every falling edge. Directed steps also check single bits for the same-cycle bypass, the dispatch-versus-completion collision and the drop-then-redispatch order.

// File: rtl/rwt_pkg.sv
package rwt_pkg;

    localparam int NUM_PREGS = 16;
    localparam int NUM_SLOTS = 8;
    localparam int TAG_W     = 5;
    localparam int NUM_SRC   = 2;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
    } cmpl_t;

    typedef struct packed {
        tag_t tag;
        logic pend;
    } src_t;

    function automatic logic is_tracked(tag_t t);
        return int'(t) < NUM_PREGS;
    endfunction

    function automatic logic sb_bit(logic [NUM_PREGS-1:0] v, tag_t t);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_PREGS; i++) begin
            if (int'(t) == i) r = v[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/rwt_scoreboard.sv
module rwt_scoreboard
    import rwt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  cmpl_t                set_in,
    input  logic                 clr_valid,
    input  tag_t                 clr_tag,
    input  tag_t                 rd_tag [NUM_SRC],
    output logic                 rd_rdy [NUM_SRC],
    output logic [NUM_PREGS-1:0] bits
);

    logic [NUM_PREGS-1:0] bits_q;
    logic [NUM_PREGS-1:0] bits_d;

    always_comb begin
        bits_d = bits_q;
        for (int i = 0; i < NUM_PREGS; i++) begin
            if (set_in.valid && int'(set_in.tag) == i) bits_d[i] = 1'b1;
            if (clr_valid && int'(clr_tag) == i)       bits_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bits_q <= '0;
        else     bits_q <= bits_d;
    end

    // read with bypass from a completion in the same cycle
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_rd
        assign rd_rdy[s] = sb_bit(bits_q, rd_tag[s]) ||
                           (set_in.valid && set_in.tag == rd_tag[s]);
    end

    assign bits = bits_q;

    assert_dst_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (clr_valid && is_tracked(clr_tag)) |=> !sb_bit(bits_q, $past(clr_tag)));

    assert_cmpl_set_R5: assert property (@(posedge clk) disable iff (rst)
        (set_in.valid && is_tracked(set_in.tag) &&
         !(clr_valid && clr_tag == set_in.tag))
        |=> sb_bit(bits_q, $past(set_in.tag)));

    assert_untracked_R7: assert property (@(posedge clk) disable iff (rst)
        ((!clr_valid || !is_tracked(clr_tag)) &&
         (!set_in.valid || !is_tracked(set_in.tag))) |=> $stable(bits_q));

endmodule

// File: rtl/rwt_slot.sv
module rwt_slot
    import rwt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  src_t  src_in [NUM_SRC],
    input  cmpl_t wake,
    input  logic  drop,
    input  tag_t  probe_tag,
    output logic  ready,
    output logic  waits_on_probe
);

    src_t src_q [NUM_SRC];
    logic valid_q;
    logic any_pend;
    logic load_clean;
    logic probe_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            for (int s = 0; s < NUM_SRC; s++) src_q[s] <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            for (int s = 0; s < NUM_SRC; s++) src_q[s] <= src_in[s];
        end else if (drop) begin
            valid_q <= 1'b0;
            for (int s = 0; s < NUM_SRC; s++) src_q[s].pend <= 1'b0;
        end else begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (wake.valid && src_q[s].pend && src_q[s].tag == wake.tag)
                    src_q[s].pend <= 1'b0;
            end
        end
    end

    always_comb begin
        any_pend   = 1'b0;
        load_clean = 1'b1;
        probe_hit  = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (src_q[s].pend) any_pend = 1'b1;
            if (src_in[s].pend) load_clean = 1'b0;
            if (src_q[s].pend && src_q[s].tag == probe_tag &&
                !(wake.valid && wake.tag == probe_tag))
                probe_hit = 1'b1;
        end
    end

    assign ready          = valid_q && !any_pend;
    assign waits_on_probe = valid_q && !drop && !load && probe_hit;

    assert_load_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (load && load_clean) |=> ready);

    assert_drop_empty_R9: assert property (@(posedge clk) disable iff (rst)
        (drop && !load) |=> !ready);

    assert_ready_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (ready && !load && !drop) |=> ready);

endmodule

// File: rtl/regwake_tracker.sv
module regwake_tracker
    import rwt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 disp_valid,
    input  logic [SLOT_W-1:0]    disp_slot,
    input  logic [TAG_W-1:0]     disp_src0_tag,
    input  logic [TAG_W-1:0]     disp_src1_tag,
    input  logic [NUM_SRC-1:0]   disp_src_rdy,
    input  logic [TAG_W-1:0]     disp_dst_tag,
    input  logic                 cmpl_valid,
    input  logic [TAG_W-1:0]     cmpl_tag,
    input  logic [NUM_SLOTS-1:0] drop_mask,
    output logic [NUM_SLOTS-1:0] slot_ready,
    output logic [NUM_PREGS-1:0] reg_ready,
    output logic                 producer_err
);

    tag_t  src_tag [NUM_SRC];
    logic  sb_rdy  [NUM_SRC];
    src_t  new_src [NUM_SRC];
    cmpl_t wake;
    logic  dst_trk;
    logic  [NUM_SLOTS-1:0] waits;
    logic  err_q;

    assign src_tag[0] = disp_src0_tag;
    assign src_tag[1] = disp_src1_tag;
    assign wake.valid = cmpl_valid && is_tracked(cmpl_tag);
    assign wake.tag   = cmpl_tag;
    assign dst_trk    = disp_valid && is_tracked(disp_dst_tag);

    rwt_scoreboard u_sb (
        .clk      (clk),
        .rst      (rst),
        .set_in   (wake),
        .clr_valid(dst_trk),
        .clr_tag  (disp_dst_tag),
        .rd_tag   (src_tag),
        .rd_rdy   (sb_rdy),
        .bits     (reg_ready)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign new_src[s].tag  = src_tag[s];
        assign new_src[s].pend = !disp_src_rdy[s] && is_tracked(src_tag[s]) &&
                                 !sb_rdy[s];
    end

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        rwt_slot u_slot (
            .clk           (clk),
            .rst           (rst),
            .load          (disp_valid && int'(disp_slot) == k),
            .src_in        (new_src),
            .wake          (wake),
            .drop          (drop_mask[k]),
            .probe_tag     (disp_dst_tag),
            .ready         (slot_ready[k]),
            .waits_on_probe(waits[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else if (dst_trk && |waits) err_q <= 1'b1;
    end

    assign producer_err = err_q;

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        producer_err |=> producer_err);

    assert_err_raise_R8: assert property (@(posedge clk) disable iff (rst)
        (dst_trk && |waits) |=> producer_err);

endmodule

// File: tb/tb_regwake_tracker.sv
module tb_regwake_tracker;
    import rwt_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 disp_valid = 1'b0;
    logic [SLOT_W-1:0]    disp_slot = '0;
    logic [TAG_W-1:0]     disp_src0_tag = '0;
    logic [TAG_W-1:0]     disp_src1_tag = '0;
    logic [NUM_SRC-1:0]   disp_src_rdy = '0;
    logic [TAG_W-1:0]     disp_dst_tag = '0;
    logic                 cmpl_valid = 1'b0;
    logic [TAG_W-1:0]     cmpl_tag = '0;
    logic [NUM_SLOTS-1:0] drop_mask = '0;
    logic [NUM_SLOTS-1:0] slot_ready;
    logic [NUM_PREGS-1:0] reg_ready;
    logic                 producer_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;
    bit finished = 0;

    regwake_tracker dut (.*);

    always #5 clk = ~clk;

    // behavioural reference
    bit m_sb    [NUM_PREGS];
    bit m_valid [NUM_SLOTS];
    bit m_wait  [NUM_SLOTS][NUM_SRC];
    int m_tag   [NUM_SLOTS][NUM_SRC];
    bit m_err;

    always @(posedge clk) begin
        int t [NUM_SRC];
        bit np [NUM_SRC];
        int cm, dst;
        bit cmv, dv;
        cycles++;
        if (rst) begin
            started = 1;
            m_err = 0;
            for (int i = 0; i < NUM_PREGS; i++) m_sb[i] = 0;
            for (int k = 0; k < NUM_SLOTS; k++) begin
                m_valid[k] = 0;
                for (int s = 0; s < NUM_SRC; s++) begin m_wait[k][s] = 0; m_tag[k][s] = 0; end
            end
        end else begin
            t[0] = int'(disp_src0_tag);
            t[1] = int'(disp_src1_tag);
            cm  = int'(cmpl_tag);
            dst = int'(disp_dst_tag);
            cmv = cmpl_valid && cm < NUM_PREGS;
            dv  = disp_valid && dst < NUM_PREGS;
            if (dv) begin
                for (int k = 0; k < NUM_SLOTS; k++) begin
                    if (m_valid[k] && !drop_mask[k] && !(disp_valid && int'(disp_slot) == k)) begin
                        for (int s = 0; s < NUM_SRC; s++)
                            if (m_wait[k][s] && m_tag[k][s] == dst && !(cmv && cm == dst)) m_err = 1;
                    end
                end
            end
            for (int s = 0; s < NUM_SRC; s++)
                np[s] = !disp_src_rdy[s] && t[s] < NUM_PREGS && !m_sb[t[s] % NUM_PREGS]
                        && !(cmv && cm == t[s]);
            for (int k = 0; k < NUM_SLOTS; k++) begin
                if (disp_valid && int'(disp_slot) == k) begin
                    m_valid[k] = 1;
                    for (int s = 0; s < NUM_SRC; s++) begin m_wait[k][s] = np[s]; m_tag[k][s] = t[s]; end
                end else if (drop_mask[k]) begin
                    m_valid[k] = 0;
                    for (int s = 0; s < NUM_SRC; s++) m_wait[k][s] = 0;
                end else begin
                    for (int s = 0; s < NUM_SRC; s++)
                        if (cmv && m_wait[k][s] && m_tag[k][s] == cm) m_wait[k][s] = 0;
                end
            end
            if (cmv) m_sb[cm] = 1;
            if (dv)  m_sb[dst] = 0;
        end
    end

    function automatic logic [NUM_SLOTS-1:0] exp_ready();
        logic [NUM_SLOTS-1:0] r;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            r[k] = m_valid[k];
            for (int s = 0; s < NUM_SRC; s++) if (m_wait[k][s]) r[k] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [NUM_PREGS-1:0] exp_regs();
        logic [NUM_PREGS-1:0] r;
        for (int i = 0; i < NUM_PREGS; i++) r[i] = m_sb[i];
        return r;
    endfunction

    always @(negedge clk) begin
        if (started && !finished) begin
            checks++;
            if (slot_ready !== exp_ready() || reg_ready !== exp_regs() || producer_err !== m_err) begin
                errors++;
                $display("FAIL model R3/R5/R8: slot_ready=%h reg_ready=%h err=%b expected %h %h %b",
                         slot_ready, reg_ready, producer_err, exp_ready(), exp_regs(), m_err);
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        disp_valid = 0; cmpl_valid = 0; drop_mask = '0;
    endtask

    task automatic go();
        @(negedge clk);
        idle();
    endtask

    task automatic disp(int slot, int s0, int s1, logic [1:0] rdy, int dst);
        disp_valid = 1;
        disp_slot = SLOT_W'(slot);
        disp_src0_tag = TAG_W'(s0);
        disp_src1_tag = TAG_W'(s1);
        disp_src_rdy = rdy;
        disp_dst_tag = TAG_W'(dst);
    endtask

    task automatic cmpl(int tg);
        cmpl_valid = 1;
        cmpl_tag = TAG_W'(tg);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 20000 && !finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [NUM_PREGS-1:0] snap;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 slots", 32'(slot_ready), 0);
        chk("R1 regs", 32'(reg_ready), 0);
        chk("R1 err", 32'(producer_err), 0);

        cmpl(3); go();
        cmpl(4); go();
        chk("R5 reg3 set", 32'(reg_ready[3]), 1);
        chk("R5 reg4 set", 32'(reg_ready[4]), 1);

        disp(0, 3, 20, 2'b00, 4); go();
        chk("R3 slot0 ready", 32'(slot_ready[0]), 1);
        chk("R2 reg4 cleared", 32'(reg_ready[4]), 0);

        disp(1, 5, 4, 2'b10, 6); go();
        chk("R4 slot1 waits", 32'(slot_ready[1]), 0);
        go();
        chk("R4 slot1 still waits", 32'(slot_ready[1]), 0);
        cmpl(5); go();
        chk("R5 slot1 woken", 32'(slot_ready[1]), 1);
        chk("R5 reg5 set", 32'(reg_ready[5]), 1);

        disp(2, 6, 6, 2'b00, 11); cmpl(6); go();
        chk("R6 bypass ready", 32'(slot_ready[2]), 1);

        disp(3, 7, 22, 2'b00, 12); go();
        chk("R4 slot3 waits", 32'(slot_ready[3]), 0);
        drop_mask = 8'b0000_1000; go();
        chk("R9 dropped not ready", 32'(slot_ready[3]), 0);
        disp(4, 20, 21, 2'b00, 7); go();
        chk("R9 no waiter left", 32'(producer_err), 0);

        disp(5, 9, 9, 2'b00, 13); go();
        disp(6, 20, 20, 2'b00, 9); go();
        chk("R8 error raised", 32'(producer_err), 1);
        go();
        chk("R8 error sticky", 32'(producer_err), 1);

        cmpl(10); go();
        chk("R5 reg10 set", 32'(reg_ready[10]), 1);
        disp(7, 20, 20, 2'b11, 10); cmpl(10); go();
        chk("R10 dispatch wins", 32'(reg_ready[10]), 0);

        snap = reg_ready;
        disp(0, 28, 29, 2'b00, 30); cmpl(25); go();
        chk("R7 regs unchanged", 32'(reg_ready), 32'(snap));
        chk("R7 untracked src ready", 32'(slot_ready[0]), 1);

        drop_mask = '1; go();
        chk("R9 all dropped", 32'(slot_ready), 0);

        for (int n = 0; n < 600; n++) begin
            disp_valid = 1'($urandom % 2);
            disp_slot = SLOT_W'($urandom % NUM_SLOTS);
            disp_src0_tag = TAG_W'($urandom % 20);
            disp_src1_tag = TAG_W'($urandom % 20);
            disp_src_rdy = 2'($urandom % 4);
            disp_dst_tag = TAG_W'($urandom % 20);
            cmpl_valid = 1'($urandom % 2);
            cmpl_tag = TAG_W'($urandom % 20);
            drop_mask = ($urandom % 3 == 0) ? NUM_SLOTS'(1 << ($urandom % NUM_SLOTS)) : '0;
            if (n % 97 == 0) begin
                rst = 1; @(negedge clk); rst = 0;
            end
            @(negedge clk);
        end
        idle();
        @(negedge clk);
        finish_run();
    end

endmodule